// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Read-and-Clear

This block keeps a 64-bit signed running sum, stored as a low 32-bit half and a high 32-bit half, and updates it from two 32-bit signed operands. A qualified command either adds the full 64-bit signed product to the sum, subtracts it, or reads a fixed slice of the sum while zeroing it in the same clock. Every command completes in one clock, so a new command may be issued on every cycle without any stall. The sum wraps modulo 2^64 and never saturates.

Software or a neighbouring unit can also overwrite either half directly through a write port, and both halves are always visible on dedicated outputs. A direct write lands on the clock edge where it is presented. If a command and a direct write arrive together, the command wins and the write is discarded.

A small controller tracks what the last cycle did. It has four states: ST_IDLE (nothing happened), ST_ACCUM (a product was added or subtracted), ST_DRAIN (a read-and-clear was taken, so the result is valid), and ST_LOAD (a direct write was applied). Its transitions are named T_CMD_ACC (add or subtract command, to ST_ACCUM), T_CMD_RDC (read-and-clear, to ST_DRAIN), T_WRITE (direct write with no command, to ST_LOAD) and T_QUIET (neither, to ST_IDLE). Any state may take any transition.

Top module: `mac_accum`

## Requirements
- R1: After reset both accumulator halves read zero, `res_valid` is 0 and `res_data` is zero.
- R2: A command with `cmd_op` = 2'b00 adds the signed 64-bit product of `opa` and `opb` to the accumulator, wrapping modulo 2^64, visible after the same clock edge.
- R3: A command with `cmd_op` = 2'b01 subtracts the signed 64-bit product of `opa` and `opb` from the accumulator, wrapping modulo 2^64.
- R4: A command with `cmd_op` = 2'b10 loads `res_data` with bits 59 down to 28 of the accumulator value before that edge (the low 32 bits of an arithmetic right shift by 28), and `res_valid` is 1 for exactly the following cycle.
- R5: The read-and-clear command sets both accumulator halves to zero on the same edge that captures the result.
- R6: Commands may be issued on consecutive cycles; each sees the result of the one before it with no stall.
- R7: A direct write with `wr_en` = 1 replaces the low half when `wr_hi` = 0 and the high half when `wr_hi` = 1, visible after that edge, leaving the other half unchanged.
- R8: When a valid command and a direct write occur in the same cycle, the command takes effect and the write is discarded.
- R9: With no command and no write, both halves and `res_data` hold their values and `res_valid` is 0.
- R10: `cmd_op` = 2'b11 is a reserved code: with `cmd_valid` = 1 it changes neither half nor the result, and a direct write presented with it still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Qualifies `cmd_op` and the operands |
| cmd_op | input | 2 | 00 add product, 01 subtract product, 10 read-and-clear, 11 reserved |
| opa | input | 32 | First signed operand |
| opb | input | 32 | Second signed operand |
| wr_en | input | 1 | Direct write strobe for one accumulator half |
| wr_hi | input | 1 | Selects the half to write: 0 low, 1 high |
| wr_data | input | 32 | Value for the direct write |
| acc_lo | output | 32 | Low half of the accumulator |
| acc_hi | output | 32 | High half of the accumulator |
| res_data | output | 32 | Slice captured by the last read-and-clear |
| res_valid | output | 1 | High for one cycle after a read-and-clear |

## Verification
The two functions that can meet in one cycle are a command on the arithmetic path and a direct write to one half of the sum. The bench drives both in the same cycle for add, subtract and read-and-clear, and judges the outcome by the reference model's rule that the command's result appears on `acc_lo`/`acc_hi` while the written value is lost. It also drives a write beside the reserved code, where the write must land because no command is taken.

// File: rtl/mac_pkg.sv
package mac_pkg;

    // Command codes seen on the command port
    typedef enum logic [1:0] {
        OP_MAC = 2'b00,
        OP_MSB = 2'b01,
        OP_RDC = 2'b10,
        OP_RSV = 2'b11
    } mac_op_e;

    // Controller states: what the previous cycle did
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_DRAIN = 2'd2,
        ST_LOAD  = 2'd3
    } mac_state_e;

    // Action applied to the accumulator on the current edge
    typedef enum logic [2:0] {
        ACT_HOLD = 3'd0,
        ACT_ADD  = 3'd1,
        ACT_SUB  = 3'd2,
        ACT_CLR  = 3'd3,
        ACT_LDLO = 3'd4,
        ACT_LDHI = 3'd5
    } mac_act_e;

endpackage

// File: rtl/mac_product.sv
module mac_product #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [2*DATA_W-1:0] prod
);
    localparam int unsigned PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] a_ext;
    logic signed [PROD_W-1:0] b_ext;

    // Sign-extend both operands, then keep the full-width product.
    always_comb begin
        a_ext = {{DATA_W{a[DATA_W-1]}}, a};
        b_ext = {{DATA_W{b[DATA_W-1]}}, b};
        prod  = a_ext * b_ext;
    end

endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
    import mac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       wr_en,
    input  logic       wr_hi,
    output mac_act_e   act,
    output logic       res_valid
);
    mac_state_e state;
    mac_state_e state_nxt;
    mac_op_e    op;
    logic       cmd_take;

    always_comb begin
        op       = mac_op_e'(cmd_op);
        cmd_take = cmd_valid && (op != OP_RSV);
    end

    // Decode: a taken command always has priority over a direct write.
    always_comb begin
        act       = ACT_HOLD;
        state_nxt = ST_IDLE;                       // T_QUIET
        if (cmd_take) begin
            unique case (op)
                OP_MAC: begin
                    act       = ACT_ADD;
                    state_nxt = ST_ACCUM;          // T_CMD_ACC
                end
                OP_MSB: begin
                    act       = ACT_SUB;
                    state_nxt = ST_ACCUM;          // T_CMD_ACC
                end
                OP_RDC: begin
                    act       = ACT_CLR;
                    state_nxt = ST_DRAIN;          // T_CMD_RDC
                end
                OP_RSV: begin
                    act       = ACT_HOLD;
                    state_nxt = ST_IDLE;
                end
            endcase
        end else if (wr_en) begin
            act       = wr_hi ? ACT_LDHI : ACT_LDLO;
            state_nxt = ST_LOAD;                   // T_WRITE
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Outputs from state
    always_comb begin
        unique case (state)
            ST_IDLE:  res_valid = 1'b0;
            ST_ACCUM: res_valid = 1'b0;
            ST_DRAIN: res_valid = 1'b1;
            ST_LOAD:  res_valid = 1'b0;
        endcase
    end

    AST_CMD_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op != 2'b11 && wr_en) |-> (act != ACT_LDLO && act != ACT_LDHI)); // R8

    AST_DRAIN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b10) |=> res_valid); // R4

    AST_DRAIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(cmd_valid && cmd_op == 2'b10)); // R4

    AST_RSV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b11 && wr_en) |=> (state == ST_LOAD)); // R10

endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg
    import mac_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned RD_SHIFT = 28
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  mac_act_e             act,
    input  logic [2*DATA_W-1:0]  prod,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    acc_lo,
    output logic [DATA_W-1:0]    acc_hi,
    output logic [DATA_W-1:0]    res_data
);
    localparam int unsigned ACC_W = 2 * DATA_W;

    logic [ACC_W-1:0]        acc;
    logic [ACC_W-1:0]        sum_add;
    logic [ACC_W-1:0]        sum_sub;
    logic signed [ACC_W-1:0] acc_sra;
    logic [DATA_W-1:0]       lo_nxt;
    logic [DATA_W-1:0]       hi_nxt;

    always_comb begin
        acc     = {acc_hi, acc_lo};
        sum_add = acc + prod;
        sum_sub = acc - prod;
        acc_sra = $signed(acc) >>> RD_SHIFT;
    end

    always_comb begin
        lo_nxt = acc_lo;
        hi_nxt = acc_hi;
        unique case (act)
            ACT_HOLD: ;
            ACT_ADD: begin
                lo_nxt = sum_add[DATA_W-1:0];
                hi_nxt = sum_add[ACC_W-1:DATA_W];
            end
            ACT_SUB: begin
                lo_nxt = sum_sub[DATA_W-1:0];
                hi_nxt = sum_sub[ACC_W-1:DATA_W];
            end
            ACT_CLR: begin
                lo_nxt = '0;
                hi_nxt = '0;
            end
            ACT_LDLO: lo_nxt = wr_data;
            ACT_LDHI: hi_nxt = wr_data;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_lo <= '0;
            acc_hi <= '0;
        end else begin
            acc_lo <= lo_nxt;
            acc_hi <= hi_nxt;
        end
    end

    // Result capture happens only on read-and-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_data <= '0;
        end else if (act == ACT_CLR) begin
            res_data <= acc_sra[DATA_W-1:0];
        end
    end

    AST_ADD_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_ADD) |=> ({acc_hi, acc_lo} == $past({acc_hi, acc_lo} + prod))); // R2

    AST_SUB_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_SUB) |=> ({acc_hi, acc_lo} == $past({acc_hi, acc_lo} - prod))); // R3

    AST_LOAD_KEEPS_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_LDLO) |=> (acc_hi == $past(acc_hi) && acc_lo == $past(wr_data))); // R7

endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned RD_SHIFT = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] acc_lo,
    output logic [DATA_W-1:0] acc_hi,
    output logic [DATA_W-1:0] res_data,
    output logic              res_valid
);
    localparam int unsigned ACC_W = 2 * DATA_W;

    mac_act_e         act;
    logic [ACC_W-1:0] prod;

    mac_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .wr_en     (wr_en),
        .wr_hi     (wr_hi),
        .act       (act),
        .res_valid (res_valid)
    );

    mac_product #(.DATA_W(DATA_W)) u_prod (
        .a    (opa),
        .b    (opb),
        .prod (prod)
    );

    mac_acc_reg #(.DATA_W(DATA_W), .RD_SHIFT(RD_SHIFT)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .prod     (prod),
        .wr_data  (wr_data),
        .acc_lo   (acc_lo),
        .acc_hi   (acc_hi),
        .res_data (res_data)
    );

    AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b10) |=> (acc_lo == '0 && acc_hi == '0)); // R5

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cmd_valid || cmd_op == 2'b11) && !wr_en) |=>
        ($stable(acc_lo) && $stable(acc_hi) && $stable(res_data) && !res_valid)); // R9

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_op == 2'b10) |=> $stable(res_data)); // R4

endmodule

// File: tb/mac_accum_tb.sv
module mac_accum_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        wr_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] acc_lo;
    logic [31:0] acc_hi;
    logic [31:0] res_data;
    logic        res_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] acc;
        logic        rv;
        logic [31:0] rd;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    logic [63:0] m_acc = '0;
    logic [31:0] m_res = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_accum u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .opa(opa), .opb(opb), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
        .acc_lo(acc_lo), .acc_hi(acc_hi), .res_data(res_data), .res_valid(res_valid)
    );

    // Driver: present one cycle of stimulus and push the expected outcome.
    task automatic drive(input bit cv, input logic [1:0] op, input logic [31:0] a,
                         input logic [31:0] b, input bit we, input bit wh,
                         input logic [31:0] wd, input string req);
        exp_t e;
        logic signed [63:0] p;
        logic signed [63:0] sh;
        bit rv;
        @(negedge clk);
        cmd_valid = cv; cmd_op = op; opa = a; opb = b;
        wr_en = we; wr_hi = wh; wr_data = wd;
        p  = longint'($signed(a)) * longint'($signed(b));
        rv = 1'b0;
        if (cv && op != 2'b11) begin
            case (op)
                2'b00: m_acc = m_acc + p;
                2'b01: m_acc = m_acc - p;
                default: begin
                    sh    = $signed(m_acc) >>> 28;
                    m_res = sh[31:0];
                    m_acc = '0;
                    rv    = 1'b1;
                end
            endcase
        end else if (we) begin
            if (wh) m_acc[63:32] = wd;
            else    m_acc[31:0]  = wd;
        end
        e.acc = m_acc; e.rv = rv; e.rd = m_res; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic idle(input string req);
        drive(1'b0, 2'b00, 32'd0, 32'd0, 1'b0, 1'b0, 32'd0, req);
    endtask

    // Monitor: pop after each edge and compare against the ports.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if ({acc_hi, acc_lo} !== e.acc || res_valid !== e.rv || res_data !== e.rd) begin
                errors++;
                $display("FAIL %s: acc=%h rv=%b rd=%h expected acc=%h rv=%b rd=%h",
                         e.req, {acc_hi, acc_lo}, res_valid, res_data, e.acc, e.rv, e.rd);
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        checks++;
        if ({acc_hi, acc_lo} !== 64'd0 || res_valid !== 1'b0 || res_data !== 32'd0) begin
            errors++;
            $display("FAIL R1: acc=%h rv=%b rd=%h expected acc=0 rv=0 rd=0",
                     {acc_hi, acc_lo}, res_valid, res_data);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 after release");

        // R2 add products, R6 back-to-back
        drive(1, 2'b00, 32'd3, 32'd5, 0, 0, 0, "R2 add 3*5");
        drive(1, 2'b00, -32'sd7, 32'd9, 0, 0, 0, "R2 add -7*9 R6");
        // R3 subtract
        drive(1, 2'b01, 32'd4, -32'sd2, 0, 0, 0, "R3 sub 4*-2");
        drive(1, 2'b01, 32'd100000, 32'd100000, 0, 0, 0, "R3 sub large");
        // R4 R5 read-and-clear on negative value
        drive(1, 2'b10, 0, 0, 0, 0, 0, "R4 R5 read-clear negative");
        idle("R9 hold after read");
        // R9 quiet with noise on operands
        drive(0, 2'b00, 32'h1234, 32'h5678, 0, 0, 0, "R9 quiet operands");
        // large positive then read
        drive(1, 2'b00, 32'h7fffffff, 32'h7fffffff, 0, 0, 0, "R2 max product");
        drive(1, 2'b00, 32'h80000000, 32'h80000000, 0, 0, 0, "R2 min*min R6");
        drive(1, 2'b10, 0, 0, 0, 0, 0, "R4 R5 read-clear positive R6");
        drive(1, 2'b00, 32'd2, 32'd2, 0, 0, 0, "R6 add right after clear");
        // R7 direct writes
        drive(0, 2'b00, 0, 0, 1, 1, 32'h7fffffff, "R7 write high");
        drive(0, 2'b00, 0, 0, 1, 0, 32'hffffffff, "R7 write low");
        // wrap through top of range
        drive(1, 2'b00, 32'd1, 32'd1, 0, 0, 0, "R2 wrap to sign");
        drive(1, 2'b01, 32'd1, 32'd1, 0, 0, 0, "R3 wrap back");
        // R8 conflicts
        drive(1, 2'b00, 32'd10, 32'd10, 1, 0, 32'hdeadbeef, "R8 add beats write");
        drive(1, 2'b01, 32'd3, 32'd3, 1, 1, 32'hcafef00d, "R8 sub beats write");
        drive(1, 2'b10, 0, 0, 1, 0, 32'h0badf00d, "R8 read-clear beats write");
        idle("R4 result held");
        // R10 reserved code
        drive(0, 2'b00, 0, 0, 1, 0, 32'h10000000, "R7 write low again");
        drive(1, 2'b11, 32'd50, 32'd50, 0, 0, 0, "R10 reserved no effect");
        drive(1, 2'b11, 32'd50, 32'd50, 1, 1, 32'h00000005, "R10 reserved with write");
        drive(1, 2'b10, 0, 0, 0, 0, 0, "R4 read-clear after writes");
        drive(1, 2'b10, 0, 0, 0, 0, 0, "R5 read-clear of zero");
        idle("R9 final hold");
        idle("R9 final hold 2");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule